// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block is the slave-side status logic of a serial flash command port. It watches the raw serial clock, chip select and data-in lines, brings them into the system clock domain, and decodes each chip-select frame into an opcode and the bits that follow. It holds two 8-bit status registers, a write-enable latch and a busy flag. It answers status read commands on the serial data-out line and runs a self-timed update cycle when a status write is accepted.

Register 1 carries busy in bit 0, the write-enable latch in bit 1, and five software-writable protection bits in positions 7, 5, 4, 3 and 2. Bit 6 is read-only and reads 0. Register 2 has two writable bits: bit 1 is the quad-enable flag and bit 0 is a second protect flag. Its other bits read 0. A status write of one data byte loads register 1 and forces both writable bits of register 2 to 0. A status write of two data bytes loads register 1 from the first byte and register 2 from the second. The serial timing is SPI mode 0: the block samples data-in on the rising serial clock and shifts data-out on the falling one.

Top module: `flash_status_unit`

## Requirements
- R1: After reset both status registers read 0x00. This means busy and the write-enable latch are both clear.
- R2: A frame holding opcode 0x06 and exactly 8 bits sets register 1 bit 1. A frame holding opcode 0x04 and exactly 8 bits clears it. A frame of any other length carrying 0x06 leaves the latch unchanged.
- R3: A status write (opcode 0x01) sent while the write-enable latch is 0 changes neither register and does not start a cycle.
- R4: An accepted status write changes only register 1 bits 7, 5, 4, 3 and 2 and register 2 bits 1 and 0. Register 1 bit 6 and register 2 bits 7 to 2 stay 0 whatever data is sent.
- R5: A status write is accepted only when chip select rises after exactly 8 or exactly 16 data bits. For any other count the registers, busy and the latch all keep their values.
- R6: An accepted status write with 8 data bits clears register 2 bits 1 and 0.
- R7: An accepted status write sets busy (register 1 bit 0) for exactly TW_CYCLES system clocks. When busy drops, the write-enable latch drops with it.
- R8: Opcode 0x05 returns register 1 and opcode 0x35 returns register 2, MSB first. Each bit is shifted out on the falling serial clock. The same byte repeats for as long as chip select stays low.
- R9: Status reads are answered during the busy cycle and show busy = 1.
- R10: While busy, the write-enable, write-disable and status-write opcodes have no effect.
- R11: Data-out stays 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| cs_n_i | input | 1 | Chip select from the host, active low, asynchronous |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial status data to the host |

## Verification
The embedded assertions watch several properties on every clock. They check that a cycle only ever starts from a set latch, and that the stored protection bits move only when a cycle starts. They check that a one-byte write leaves the register 2 flags at zero, that the busy window lasts exactly TW_CYCLES, and that the latch is low when busy ends. They also check that data-out only moves on a falling serial clock and stays low outside a read. The bench scenarios are needed for the rest. They show frame decoding end to end: the bit masks as seen through real reads, rejection at wrong lengths, commands ignored during busy, MSB-first ordering and repeated read bytes.

// File: rtl/fsr_pkg.sv
// Shared constants and the frame record for the status register unit.
package fsr_pkg;
    localparam int CNT_W = 5;               // frame bit counter width, saturating
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_RDSR1 = 8'h05;
    localparam logic [7:0] OP_RDSR2 = 8'h35;
    localparam logic [7:0] SR1_WMASK = 8'hBC;   // writable bits 7,5,4,3,2
    localparam logic [7:0] SR2_WMASK = 8'h03;   // quad-enable bit 1, protect bit 0
    localparam logic [CNT_W-1:0] LEN_OP     = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_SHORT  = CNT_W'(16);
    localparam logic [CNT_W-1:0] LEN_LONG   = CNT_W'(24);

    // One completed chip-select frame, reported when chip select rises.
    typedef struct packed {
        logic             valid;
        logic [7:0]       op;
        logic [CNT_W-1:0] nbits;
        logic [15:0]      data;   // last 16 bits received, newest in bit 0
    } fsr_frame_t;
endpackage

// File: rtl/fsr_spi_rx.sv
// Serial receiver: synchronizes the host lines into clk, detects clock and
// select edges, counts the bits of a frame and reports the opcode and frame end.
// Assumes the host holds each line for several system clocks (sck slower than clk/4).
module fsr_spi_rx
    import fsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    output logic       sck_fall,
    output logic       op_done,
    output logic [7:0] op_code,
    output fsr_frame_t frame
);
    logic [SYNC_STAGES:0]   sck_p;
    logic [SYNC_STAGES:0]   cs_p;
    logic [SYNC_STAGES-1:0] mosi_p;
    logic [CNT_W-1:0]       cnt;
    logic [15:0]            sreg;
    logic sck_s, sck_d, cs_s, cs_d, mosi_s, sck_rise, cs_rise, cs_fall;

    // Synchronizer chains; the extra stage on sck and cs serves edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[SYNC_STAGES-1:0], sck_i};
            cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n_i};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi_i};
        end
    end

    // Edge decode on the synchronized lines.
    always_comb begin
        sck_s    = sck_p[SYNC_STAGES-1];
        sck_d    = sck_p[SYNC_STAGES];
        cs_s     = cs_p[SYNC_STAGES-1];
        cs_d     = cs_p[SYNC_STAGES];
        mosi_s   = mosi_p[SYNC_STAGES-1];
        sck_rise = sck_s & ~sck_d & ~cs_s;
        sck_fall = ~sck_s & sck_d & ~cs_s;
        cs_rise  = cs_s & ~cs_d;
        cs_fall  = ~cs_s & cs_d;
    end

    // Bit counting, shifting and opcode capture within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            sreg    <= '0;
            op_code <= '0;
            op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (cs_fall) begin
                cnt <= '0;
            end else if (sck_rise) begin
                sreg <= {sreg[14:0], mosi_s};
                if (cnt != '1) cnt <= cnt + 1'b1;
                if (cnt == LEN_OP - 1'b1) begin
                    op_code <= {sreg[6:0], mosi_s};
                    op_done <= 1'b1;
                end
            end
        end
    end

    // Frame report, one cycle wide, on the rising chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else begin
            frame.valid <= cs_rise;
            frame.op    <= op_code;
            frame.nbits <= cnt;
            frame.data  <= sreg;
        end
    end
endmodule

// File: rtl/fsr_regs.sv
// Status storage, write-enable latch and the self-timed status write cycle.
// Acts on completed frames only; while busy all write-type frames are dropped.
module fsr_regs
    import fsr_pkg::*;
#(
    parameter int TW_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  fsr_frame_t frame,
    output logic [7:0] sr1_view,
    output logic [7:0] sr2_view
);
    localparam int TW_W = $clog2(TW_CYCLES + 1);

    logic [7:0]      nv1, nv2;
    logic            wel, busy;
    logic [TW_W-1:0] tmr;
    logic [TW_W-1:0] wcnt;
    logic            len8, len16, wr_ok;
    logic [7:0]      d1, d2;

    // Decode of a status write frame: length, data bytes and acceptance.
    always_comb begin
        len8  = (frame.nbits == LEN_SHORT);
        len16 = (frame.nbits == LEN_LONG);
        d1    = len16 ? frame.data[15:8] : frame.data[7:0];
        d2    = len16 ? frame.data[7:0]  : 8'h00;
        wr_ok = frame.valid && !busy && wel && (frame.op == OP_WRSR) && (len8 || len16);
    end

    // Register state: latch commands, status commit and busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv1  <= '0;
            nv2  <= '0;
            wel  <= 1'b0;
            busy <= 1'b0;
            tmr  <= '0;
        end else if (busy) begin
            if (tmr == '0) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end else if (wr_ok) begin
            nv1  <= (nv1 & ~SR1_WMASK) | (d1 & SR1_WMASK);
            nv2  <= (nv2 & ~SR2_WMASK) | (d2 & SR2_WMASK);
            busy <= 1'b1;
            tmr  <= TW_W'(TW_CYCLES - 1);
        end else if (frame.valid && frame.nbits == LEN_OP) begin
            if (frame.op == OP_WREN) wel <= 1'b1;
            if (frame.op == OP_WRDI) wel <= 1'b0;
        end
    end

    // Read views presented to the serializer.
    always_comb begin
        sr1_view = (nv1 & SR1_WMASK) | {6'b0, wel, busy};
        sr2_view = nv2 & SR2_WMASK;
    end

    // Length of the current busy window, used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)    wcnt <= '0;
        else if (busy) wcnt <= wcnt + 1'b1;
        else           wcnt <= '0;
    end

    AST_CYCLE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R3
    AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> ($stable(nv1) && $stable(nv2))); // R5
    AST_SHORT_CLEARS_SR2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(frame.nbits) == LEN_SHORT) |-> (sr2_view[1:0] == 2'b00)); // R6
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (wcnt == TW_W'(TW_CYCLES))); // R7
    AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R7
    AST_LATCH_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmr != '0) |=> $stable(wel)); // R10
endmodule

// File: rtl/fsr_rd_shift.sv
// Status read serializer: after a read opcode it shifts the selected register
// MSB first on each falling serial clock, re-sampling it at every byte start.
module fsr_rd_shift
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_done,
    input  logic [7:0] op_code,
    input  logic       frame_end,
    input  logic       sck_fall,
    input  logic [7:0] sr1_view,
    input  logic [7:0] sr2_view,
    output logic       miso
);
    logic       act, sel;
    logic [2:0] bcnt;
    logic [7:0] sh;
    logic [7:0] live;

    // Register picked by the current read opcode.
    always_comb live = sel ? sr2_view : sr1_view;

    // Read state and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            sel  <= 1'b0;
            bcnt <= '0;
            sh   <= '0;
            miso <= 1'b0;
        end else if (frame_end) begin
            act  <= 1'b0;
            miso <= 1'b0;
        end else if (op_done) begin
            act  <= (op_code == OP_RDSR1) || (op_code == OP_RDSR2);
            sel  <= (op_code == OP_RDSR2);
            bcnt <= '0;
        end else if (sck_fall && act) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == '0) begin
                miso <= live[7];
                sh   <= {live[6:0], 1'b0};
            end else begin
                miso <= sh[7];
                sh   <= {sh[6:0], 1'b0};
            end
        end
    end

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !miso); // R11
    AST_MISO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !frame_end) |=> $stable(miso)); // R8
endmodule

// File: rtl/flash_status_unit.sv
// Top of the status register unit: receiver, register bank and read serializer.
// Assumes SPI mode 0 host timing with sck well below the system clock rate.
module flash_status_unit
    import fsr_pkg::*;
#(
    parameter int TW_CYCLES   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic miso_o
);
    logic       sck_fall, op_done;
    logic [7:0] op_code, sr1_view, sr2_view;
    fsr_frame_t frame;

    fsr_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i),
        .sck_fall(sck_fall), .op_done(op_done), .op_code(op_code), .frame(frame)
    );

    fsr_regs #(.TW_CYCLES(TW_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame(frame),
        .sr1_view(sr1_view), .sr2_view(sr2_view)
    );

    fsr_rd_shift u_shift (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_code(op_code),
        .frame_end(frame.valid), .sck_fall(sck_fall),
        .sr1_view(sr1_view), .sr2_view(sr2_view), .miso(miso_o)
    );
endmodule

// File: tb/flash_status_unit_test.sv
module flash_status_unit_test;
    localparam int TW   = 1000;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int total = 0;
    int bad = 0;
    int idle = 0;
    bit done = 1'b0;
    logic [63:0] rx_bits = '0;

    // Behavioural model of the register contents.
    logic [7:0] m_nv1 = 8'h00;
    logic [7:0] m_sr2 = 8'h00;
    logic       m_wel = 1'b0;

    always #2 clk = ~clk;

    flash_status_unit #(.TW_CYCLES(TW)) uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi), .miso_o(miso)
    );

    function automatic logic [7:0] exp_sr1(input logic busy);
        return (m_nv1 & 8'hBC) | {6'b0, m_wel, busy};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One chip-select frame of nbits, MSB of pat[nbits-1:0] first; captures miso at each rise.
    task automatic frame(input int nbits, input logic [31:0] pat);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = pat[i];
            wait_clk(HALF);
            rx_bits = {rx_bits[62:0], miso};
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(2 * HALF);
    endtask

    task automatic read_sr(input logic [7:0] op, input int nbytes);
        frame(8 + 8 * nbytes, 32'(op) << (8 * nbytes));
    endtask

    function automatic logic [7:0] rx_byte(input int nbytes, input int k);
        return rx_bits[8 * (nbytes - 1 - k) +: 8];
    endfunction

    // Per-clock comparison: data-out must be low with chip select high (R11).
    always @(negedge clk) begin
        if (cs_n) idle++;
        else      idle = 0;
        if (rst_n && cs_n && idle >= 8) check("R11 miso idle", {7'b0, miso}, 8'h00);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset values
        read_sr(8'h05, 1); check("R1 sr1", rx_byte(1, 0), 8'h00);
        read_sr(8'h35, 1); check("R1 sr2", rx_byte(1, 0), 8'h00);

        // R2: latch set and clear, wrong length ignored
        frame(8, 32'h06); m_wel = 1'b1;
        read_sr(8'h05, 1); check("R2 set", rx_byte(1, 0), exp_sr1(1'b0));
        frame(8, 32'h04); m_wel = 1'b0;
        read_sr(8'h05, 1); check("R2 clear", rx_byte(1, 0), exp_sr1(1'b0));
        frame(16, 32'h0600);
        read_sr(8'h05, 1); check("R2 length", rx_byte(1, 0), exp_sr1(1'b0));

        // R3: status write without latch
        frame(16, 32'h01FF);
        read_sr(8'h05, 1); check("R3 sr1", rx_byte(1, 0), exp_sr1(1'b0));
        read_sr(8'h35, 1); check("R3 sr2", rx_byte(1, 0), m_sr2);

        // R9 R10 R4 R7: long write, commands during busy, then end of cycle
        frame(8, 32'h06); m_wel = 1'b1;
        frame(24, 32'h01FFFF); m_nv1 = 8'hBC; m_sr2 = 8'h03;
        frame(8, 32'h04);
        frame(16, 32'h0100);
        read_sr(8'h05, 1); check("R9 R10 busy read", rx_byte(1, 0), exp_sr1(1'b1));
        wait_clk(TW + 200); m_wel = 1'b0;
        read_sr(8'h05, 1); check("R7 after cycle", rx_byte(1, 0), exp_sr1(1'b0));
        read_sr(8'h35, 1); check("R4 sr2 set", rx_byte(1, 0), m_sr2);

        // R6: one-byte write clears register 2 flags
        frame(8, 32'h06); m_wel = 1'b1;
        frame(16, 32'h0184); m_nv1 = 8'h84; m_sr2 = 8'h00;
        wait_clk(TW + 200); m_wel = 1'b0;
        read_sr(8'h05, 1); check("R6 sr1", rx_byte(1, 0), exp_sr1(1'b0));
        read_sr(8'h35, 1); check("R6 sr2", rx_byte(1, 0), m_sr2);

        // R5: wrong data lengths cancel the write
        frame(8, 32'h06); m_wel = 1'b1;
        frame(20, 32'h01ABC);
        frame(15, 32'h00FF);
        frame(25, 32'h3FFFF);
        read_sr(8'h05, 1); check("R5 sr1", rx_byte(1, 0), exp_sr1(1'b0));
        read_sr(8'h35, 1); check("R5 sr2", rx_byte(1, 0), m_sr2);

        // R4: read-only positions stay zero
        frame(24, 32'h0143FC); m_nv1 = 8'h00; m_sr2 = 8'h00;
        wait_clk(TW + 200); m_wel = 1'b0;
        read_sr(8'h05, 1); check("R4 sr1 mask", rx_byte(1, 0), exp_sr1(1'b0));
        read_sr(8'h35, 1); check("R4 sr2 mask", rx_byte(1, 0), m_sr2);

        // R8: MSB-first order and repeated bytes
        frame(8, 32'h06); m_wel = 1'b1;
        frame(24, 32'h012802); m_nv1 = 8'h28; m_sr2 = 8'h02;
        wait_clk(TW + 200); m_wel = 1'b0;
        read_sr(8'h35, 3);
        for (int k = 0; k < 3; k++) check("R8 sr2 repeat", rx_byte(3, k), m_sr2);
        read_sr(8'h05, 3);
        for (int k = 0; k < 3; k++) check("R8 sr1 repeat", rx_byte(3, k), exp_sr1(1'b0));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule